// File: doc/BRIEF.md
# Scanline IRQ Down-Counter

This block raises an interrupt after a programmed number of rendered video lines. The CPU side writes through four register addresses. One loads the counter, one loads the reload value, one stops counting and one starts it. Each of the four writes also acknowledges a pending interrupt. The video side sends a one-cycle strobe per line, together with the 9-bit line number and a flag that says whether rendering is on.

Each qualified strobe checks the counter before it decrements. A counter that is already zero expires: the request flag is set and the counter is reloaded from the reload value. Any other value is decremented by one. The first visible line (line 0) takes one extra decrement before this check when the counter is nonzero. While a request is pending, the counter is frozen. The interrupt output stays high until the CPU acknowledges it.

Control is a three-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | counting is off |
| `ST_ARMED` | counting is on and no request is pending |
| `ST_PENDING` | a request is pending |

| Transition | From | To | Cause |
|---|---|---|---|
| `T_ENABLE` | any state | `ST_ARMED` | enable write |
| `T_DISABLE` | any state | `ST_IDLE` | disable write |
| `T_EXPIRE` | `ST_ARMED` | `ST_PENDING` | qualified strobe finds the counter at zero |
| `T_ACK` | `ST_PENDING` | `ST_ARMED` | counter-load or reload-load write |

Top module: `scanline_irq_ctr`

## Requirements
- R1: After reset, the counter and the reload value are 0, counting is off and `irq` is low.
- R2: The address is ANDed with 0xF7FF before decoding. Masked 0xC000 loads the counter with `wr_data`, and masked 0xC001 loads the reload value. Every other masked address has no effect.
- R3: Masked 0xE000 turns counting off, and masked 0xE001 turns it on.
- R4: A write to any of the four decoded addresses clears a pending request, so `irq` is low in the cycle after that write.
- R5: A strobe counts only when `line_num` is in 0..239 and `render_en` is high.
- R6: A strobe counts only while counting is on and no request is pending. During a pending request the counter holds its value.
- R7: A counting strobe that finds the (line-0-adjusted) counter at zero sets the request, so `irq` is high in the following cycle, and reloads the counter from the reload value. Otherwise the strobe decrements the counter by one.
- R8: On a counting strobe with `line_num` 0 and a nonzero counter, the counter is decremented once before the zero check of R7.
- R9: A strobe in the same cycle as a write to a decoded address is ignored.
- R10: `irq` is driven from a register and stays high until one of the four decoded writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_stb | input | 1 | one-cycle pulse per video line |
| line_num | input | 9 | number of the current line |
| render_en | input | 1 | rendering is enabled |
| irq | output | 1 | interrupt request, active high |

## Verification
A vector table loads different counter values and counts the strobes until `irq` rises. It uses mid-frame lines, line 0 and the window edges 239 and 240, which separates the plain decrement from the extra line-0 decrement and from out-of-window or non-rendering strobes that must not count. Directed sequences then check three things:
- The pending freeze, by counting strobes after an acknowledgement.
- The alias address given by the mask, and the unmapped writes that must leave the counter alone.
- The write-over-strobe collision, where a counter at zero must still be zero afterwards.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_PENDING = 2'd2
    } irq_state_t;

    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_LOAD_COUNT = 3'd1,
        CMD_LOAD_RELOAD= 3'd2,
        CMD_STOP       = 3'd3,
        CMD_START      = 3'd4
    } reg_cmd_t;
endpackage

// File: rtl/scanline_irq_decode.sv
module scanline_irq_decode
    import scanline_irq_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] ADDR_MASK  = 16'hF7FF,
    parameter logic [15:0] A_COUNT    = 16'hC000,
    parameter logic [15:0] A_RELOAD   = 16'hC001,
    parameter logic [15:0] A_STOP     = 16'hE000,
    parameter logic [15:0] A_START    = 16'hE001
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output reg_cmd_t          cmd,
    output logic              hit
);
    logic [ADDR_W-1:0] masked;

    always_comb begin
        masked = wr_addr & ADDR_MASK[ADDR_W-1:0];
        cmd    = CMD_NONE;
        if (wr_en) begin
            if (masked == A_COUNT[ADDR_W-1:0])       cmd = CMD_LOAD_COUNT;
            else if (masked == A_RELOAD[ADDR_W-1:0]) cmd = CMD_LOAD_RELOAD;
            else if (masked == A_STOP[ADDR_W-1:0])   cmd = CMD_STOP;
            else if (masked == A_START[ADDR_W-1:0])  cmd = CMD_START;
        end
        hit = (cmd != CMD_NONE);
    end
endmodule

// File: rtl/scanline_irq_qualify.sv
module scanline_irq_qualify #(
    parameter int LINE_W   = 9,
    parameter int LAST_VIS = 239
) (
    input  logic              line_stb,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_en,
    input  logic              wr_hit,
    output logic              tick,
    output logic              first_line
);
    localparam logic [LINE_W-1:0] LAST_L = LINE_W'(LAST_VIS);

    always_comb begin
        tick       = line_stb && render_en && !wr_hit && (line_num <= LAST_L);
        first_line = (line_num == '0);
    end
endmodule

// File: rtl/scanline_irq_count.sv
module scanline_irq_count #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_count,
    input  logic              load_reload,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              count_go,
    input  logic              first_line,
    output logic              expire,
    output logic [DATA_W-1:0] count_val
);
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] adj;

    always_comb begin
        adj    = (first_line && count_q != '0) ? count_q - 1'b1 : count_q;
        expire = count_go && (adj == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            if (load_count)      count_q <= wr_data;
            else if (count_go)   count_q <= (adj == '0) ? reload_q : adj - 1'b1;
            if (load_reload)     reload_q <= wr_data;
        end
    end

    assign count_val = count_q;
endmodule

// File: rtl/scanline_irq_fsm.sv
module scanline_irq_fsm
    import scanline_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  reg_cmd_t   cmd,
    input  logic       expire,
    output irq_state_t state,
    output logic       irq
);
    irq_state_t state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (cmd)
            CMD_START:  state_n = ST_ARMED;
            CMD_STOP:   state_n = ST_IDLE;
            CMD_LOAD_COUNT, CMD_LOAD_RELOAD:
                if (state_q == ST_PENDING) state_n = ST_ARMED;
            CMD_NONE:
                if (state_q == ST_ARMED && expire) state_n = ST_PENDING;
            default:    state_n = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (state_n == ST_PENDING);
    end

    assign state = state_q;
endmodule

// File: rtl/scanline_irq_ctr.sv
module scanline_irq_ctr
    import scanline_irq_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int LINE_W   = 9,
    parameter int LAST_VIS = 239
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              line_stb,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_en,
    output logic              irq
);
    reg_cmd_t          cmd;
    logic              wr_hit;
    logic              tick;
    logic              first_line;
    logic              expire;
    logic [DATA_W-1:0] cnt_val;
    irq_state_t        state;
    logic              count_go;

    scanline_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .cmd     (cmd),
        .hit     (wr_hit)
    );

    scanline_irq_qualify #(.LINE_W(LINE_W), .LAST_VIS(LAST_VIS)) u_qual (
        .line_stb   (line_stb),
        .line_num   (line_num),
        .render_en  (render_en),
        .wr_hit     (wr_hit),
        .tick       (tick),
        .first_line (first_line)
    );

    assign count_go = tick && (state == ST_ARMED);

    scanline_irq_count #(.DATA_W(DATA_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_count  (cmd == CMD_LOAD_COUNT),
        .load_reload (cmd == CMD_LOAD_RELOAD),
        .wr_data     (wr_data),
        .count_go    (count_go),
        .first_line  (first_line),
        .expire      (expire),
        .count_val   (cnt_val)
    );

    scanline_irq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .expire (expire),
        .state  (state),
        .irq    (irq)
    );
endmodule

module scanline_irq_chk #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int LINE_W   = 9,
    parameter int LAST_VIS = 239
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              line_stb,
    input logic [LINE_W-1:0] line_num,
    input logic              render_en,
    input logic              irq,
    input logic [DATA_W-1:0] cnt
);
    logic [15:0] m;
    logic        ack, ld_cnt, in_win;
    always_comb begin
        m      = 16'(wr_addr) & 16'hF7FF;
        ld_cnt = wr_en && (m == 16'hC000);
        ack    = wr_en && (m == 16'hC000 || m == 16'hC001 || m == 16'hE000 || m == 16'hE001);
        in_win = line_num <= LINE_W'(LAST_VIS);
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !irq);
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !irq);
    assert_pending_holds_R10: assert property (@(posedge clk) disable iff (!rst_n) irq && !ack |=> irq);
    assert_frozen_count_R6: assert property (@(posedge clk) disable iff (!rst_n) irq && !ld_cnt |=> $stable(cnt));
    assert_window_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_stb && !wr_en && (!in_win || !render_en) |=> $stable(cnt) && !$rose(irq));
    assert_rise_from_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(line_stb && render_en && in_win));
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !ld_cnt && line_stb |=> $stable(cnt));
endmodule

bind scanline_irq_ctr scanline_irq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W), .LAST_VIS(LAST_VIS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .line_stb  (line_stb),
    .line_num  (line_num),
    .render_en (render_en),
    .irq       (irq),
    .cnt       (cnt_val)
);

// File: tb/test_scanline_irq_ctr.sv
`timescale 1ns/1ps
module test_scanline_irq_ctr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       line_stb = 1'b0;
    logic [8:0] line_num = '0;
    logic       render_en = 1'b1;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    scanline_irq_ctr i_scanline_irq_ctr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .line_stb(line_stb), .line_num(line_num), .render_en(render_en), .irq(irq)
    );

    typedef struct packed {
        logic [7:0] cnt;
        logic [8:0] line;
        logic       ren;
        logic [7:0] expect_n;   // strobes until irq, 0 = never within limit
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{8'd3, 9'd10,  1'b1, 8'd4},   // R7 plain decrement
        '{8'd0, 9'd10,  1'b1, 8'd1},   // R7 expire at zero
        '{8'd3, 9'd0,   1'b1, 8'd2},   // R8 extra decrement on line 0
        '{8'd1, 9'd0,   1'b1, 8'd1},   // R8
        '{8'd4, 9'd0,   1'b1, 8'd3},   // R8
        '{8'd5, 9'd239, 1'b1, 8'd6},   // R5 last visible line counts
        '{8'd5, 9'd240, 1'b1, 8'd0},   // R5 line 240 ignored
        '{8'd2, 9'd100, 1'b0, 8'd0},   // R5 rendering off
        '{8'd2, 9'd300, 1'b1, 8'd0}    // R5 beyond window
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input logic [8:0] ln, input logic ren);
        @(negedge clk);
        line_stb = 1'b1; line_num = ln; render_en = ren;
        @(negedge clk);
        line_stb = 1'b0; render_en = 1'b1;
    endtask

    task automatic wr_and_strobe(input logic [15:0] a, input logic [7:0] d, input logic [8:0] ln);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        line_stb = 1'b1; line_num = ln; render_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; line_stb = 1'b0;
    endtask

    // strobes until irq (1-based), 0 if none within limit
    task automatic count_to_irq(input logic [8:0] ln, input logic ren, output int n);
        n = 0;
        for (int k = 1; k <= 20; k++) begin
            strobe(ln, ren);
            if (irq) begin n = k; break; end
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R1 irq after reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: counting off after reset
        strobe(9'd5, 1'b1);
        check("R1 disabled after reset", irq, 0);
        wr(16'hC001, 8'd2);
        wr(16'hE001, 8'd0);
        strobe(9'd5, 1'b1);
        check("R1 counter zero after reset", irq, 1);

        // R10: stays high without ack
        repeat (3) strobe(9'd7, 1'b1);
        repeat (4) @(negedge clk);
        check("R10 irq held", irq, 1);

        // R2 alias + R4 ack
        wr(16'hC801, 8'd2);
        check("R4 ack via alias of reload write", irq, 0);
        count_to_irq(9'd7, 1'b1, n);
        check("R6 counter frozen while pending", n, 3);

        // R3 disable then enable
        wr(16'hE000, 8'd0);
        check("R4 ack via disable", irq, 0);
        count_to_irq(9'd7, 1'b1, n);
        check("R3 no count while disabled", n, 0);
        wr(16'hE001, 8'd0);
        count_to_irq(9'd7, 1'b1, n);
        check("R3 counting after enable", n, 3);

        // R9: write collides with strobe
        wr(16'hC000, 8'd0);
        check("R4 ack via counter write", irq, 0);
        wr_and_strobe(16'hC001, 8'd9, 9'd20);
        check("R9 strobe ignored on write", irq, 0);
        strobe(9'd20, 1'b1);
        check("R9 counter still zero", irq, 1);

        // R2: unmapped writes no effect
        wr(16'hE001, 8'd0);
        wr(16'hC000, 8'd1);
        wr(16'h8000, 8'd0);
        wr(16'hA000, 8'd0);
        wr(16'hC002, 8'd0);
        count_to_irq(9'd30, 1'b1, n);
        check("R2 unmapped writes ignored", n, 2);
        wr(16'hC800, 8'd2);
        count_to_irq(9'd30, 1'b1, n);
        check("R2 counter load via alias", n, 3);

        // table
        for (int i = 0; i < NV; i++) begin
            wr(16'hE000, 8'd0);
            wr(16'hC000, TBL[i].cnt);
            wr(16'hE001, 8'd0);
            count_to_irq(TBL[i].line, TBL[i].ren, n);
            check($sformatf("R5/R7/R8 vector %0d", i), n, 32'(TBL[i].expect_n));
        end

        // R7 reload from latch after expiry
        wr(16'hE000, 8'd0);
        wr(16'hC001, 8'd4);
        wr(16'hC000, 8'd0);
        wr(16'hE001, 8'd0);
        strobe(9'd50, 1'b1);
        check("R7 expiry", irq, 1);
        wr(16'hE001, 8'd0);
        count_to_irq(9'd50, 1'b1, n);
        check("R7 reload from latch", n, 5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule